// File: doc/BRIEF.md
# Enable-Framed Static RAM Write Controller

This block turns single write requests from a synchronous host into correctly timed write cycles on an asynchronous static RAM. The write strobe goes low first. The two chip enables, one active-low and one active-high, then open and close the write window. Because the strobe is already low when the enables become active, the memory never drives its data pins during the cycle.

The host side is a valid/ready request channel that carries an address, a bank-select (mux control) value and a data word. A request is taken on any rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. While it is low, the host must hold its request and the controller ignores it. When the cycle has fully recovered, a one-cycle `done` pulse is raised, and `req_ready` rises in the same cycle.

All minimum intervals are given per speed grade in nanoseconds. They are turned into clock-cycle counts at elaboration time, using the clock period parameter. Every memory-side pin comes straight from a flop.

Top module: `sram_wr_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is taken only when `req_valid` and `req_ready` are both high at a rising edge. Requests presented while `req_ready` is 0 change no memory-side pin.
- R2: `mem_we_n` goes low in the first cycle after acceptance (setup), one cycle before the enables become active. It stays low until one cycle after the enables deassert. The enables are never active while `mem_we_n` is 1.
- R3: The enables are active together (`mem_e1_n`=0, `mem_e2`=1) for exactly N_EN consecutive cycles. Outside that window `mem_e1_n`=1 and `mem_e2`=0.
- R4: `mem_addr`, `mem_bank` and `mem_dq_out` carry the accepted request from the setup cycle onward. They hold steady until the next request is accepted.
- R5: `mem_dq_oe` is 1 from the setup cycle through the cycle right after the enables deassert (end). It is 0 during recovery and idle.
- R6: After the end cycle, a recovery phase of N_REC cycles follows with `mem_we_n`=1. The controller then returns to idle with `done`=1 for exactly one cycle.
- R7: With clock period T ns, N_EN = max(ceil(tEW/T), ceil(tAV/T)-1, ceil(tDV/T)-1, 1) and N_REC = max(ceil(tCYC/T)-N_EN-2, 1). The (tCYC, tEW, tAV, tDV) values for GRADE 0, 1 and 2 are (20,12,15,8), (25,15,20,10) and (35,20,30,15) ns.
- R8: After reset: `mem_we_n`=1, `mem_e1_n`=1, `mem_e2`=0, `mem_dq_oe`=0, `req_ready`=1, `done`=0.
- R9: A request held valid in the `done` cycle is accepted at the next edge. Back-to-back writes therefore start every N_EN+N_REC+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | AW | Write address |
| req_bank | input | BW | Mux-control / bank select |
| req_data | input | DW | Write data |
| done | output | 1 | One-cycle pulse when a write has fully recovered |
| mem_addr | output | AW | RAM address |
| mem_bank | output | BW | RAM mux control |
| mem_e1_n | output | 1 | Active-low chip enable |
| mem_e2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DW | RAM data bus, driven value |
| mem_dq_oe | output | 1 | RAM data bus output enable |

## Verification
Directed writes use an all-zero word, an all-ones word and the top bank and address. These show whether every pin phase lands on the expected cycle regardless of data values. Random writes with random idle gaps, and with random requests asserted while the controller is busy, separate correct back-pressure from a controller that latches a waiting request too early. A chain of back-to-back requests held valid through `done` checks the minimum repeat period. A bench memory model captures data when the enables close and compares the result against the written words, which catches any write that was framed wrongly.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ENABLE,
    ST_END,
    ST_RECOVER
  } wr_state_e;

  localparam int K_CYC = 0;
  localparam int K_EW  = 1;
  localparam int K_AV  = 2;
  localparam int K_DV  = 3;

  function automatic int ceil_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int grade_ns(input int grade, input int kind);
    int v;
    case (grade)
      1:       v = (kind == K_CYC) ? 25 : (kind == K_EW) ? 15 : (kind == K_AV) ? 20 : 10;
      2:       v = (kind == K_CYC) ? 35 : (kind == K_EW) ? 20 : (kind == K_AV) ? 30 : 15;
      default: v = (kind == K_CYC) ? 20 : (kind == K_EW) ? 12 : (kind == K_AV) ? 15 : 8;
    endcase
    return v;
  endfunction

  function automatic int en_cycles(input int grade, input int clk_ns);
    int n;
    n = 1;
    if (ceil_cyc(grade_ns(grade, K_EW), clk_ns) > n)     n = ceil_cyc(grade_ns(grade, K_EW), clk_ns);
    if (ceil_cyc(grade_ns(grade, K_AV), clk_ns) - 1 > n) n = ceil_cyc(grade_ns(grade, K_AV), clk_ns) - 1;
    if (ceil_cyc(grade_ns(grade, K_DV), clk_ns) - 1 > n) n = ceil_cyc(grade_ns(grade, K_DV), clk_ns) - 1;
    return n;
  endfunction

  function automatic int rec_cycles(input int grade, input int clk_ns);
    int n;
    n = ceil_cyc(grade_ns(grade, K_CYC), clk_ns) - en_cycles(grade, clk_ns) - 2;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/sram_wr_cnt.sv
module sram_wr_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // Down-counter never wraps: after a load it only moves toward zero.
  assert_cnt_nowrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0));
endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int N_EN  = 3,
  parameter int N_REC = 1,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_fire,
  input  logic          cnt_zero,
  output wr_state_e     state_q,
  output wr_state_e     state_d,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          done_q
);
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (state_q)
      ST_IDLE:    if (req_fire) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d  = ST_ENABLE;
        cnt_load = 1'b1;
        cnt_val  = CW'(N_EN - 1);
      end
      ST_ENABLE:  if (cnt_zero) state_d = ST_END;
      ST_END: begin
        state_d  = ST_RECOVER;
        cnt_load = 1'b1;
        cnt_val  = CW'(N_REC - 1);
      end
      ST_RECOVER: if (cnt_zero) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RECOVER) && cnt_zero;
    end
  end

  assert_done_in_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));
  assert_setup_after_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_state_e     state_d,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [BW-1:0] in_bank,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_bank,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          mem_e1_n,
  output logic          mem_e2,
  output logic          mem_we_n
);
  logic strobe_d, enab_d;

  assign strobe_d = (state_d == ST_SETUP) || (state_d == ST_ENABLE) || (state_d == ST_END);
  assign enab_d   = (state_d == ST_ENABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_bank   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      mem_e1_n   <= 1'b1;
      mem_e2     <= 1'b0;
      mem_we_n   <= 1'b1;
    end else begin
      if (capture) begin
        mem_addr   <= in_addr;
        mem_bank   <= in_bank;
        mem_dq_out <= in_data;
      end
      mem_we_n  <= !strobe_d;
      mem_dq_oe <= strobe_d;
      mem_e1_n  <= !enab_d;
      mem_e2    <= enab_d;
    end
  end

  assert_en_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_e1_n == !mem_e2);
  assert_oe_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe == !mem_we_n);
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int AW     = 8,
  parameter int BW     = 2,
  parameter int DW     = 16,
  parameter int GRADE  = 0,
  parameter int CLK_NS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_bank,
  input  logic [DW-1:0] req_data,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_bank,
  output logic          mem_e1_n,
  output logic          mem_e2,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);
  localparam int N_EN  = en_cycles(GRADE, CLK_NS);
  localparam int N_REC = rec_cycles(GRADE, CLK_NS);
  localparam int N_MAX = (N_EN > N_REC) ? N_EN : N_REC;
  localparam int CW    = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  wr_state_e     state_q, state_d;
  logic          cnt_load, cnt_zero, req_fire;
  logic [CW-1:0] cnt_val;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  sram_wr_fsm #(.N_EN(N_EN), .N_REC(N_REC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .cnt_zero(cnt_zero),
    .state_q(state_q), .state_d(state_d), .cnt_load(cnt_load),
    .cnt_val(cnt_val), .done_q(done)
  );

  sram_wr_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  sram_wr_pins #(.AW(AW), .BW(BW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .capture(req_fire),
    .in_addr(req_addr), .in_bank(req_bank), .in_data(req_data),
    .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_e1_n(mem_e1_n), .mem_e2(mem_e2), .mem_we_n(mem_we_n)
  );

  // Run length of the enable window, checked when it closes.
  logic [7:0] en_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_run <= '0;
    else if (mem_e1_n) en_run <= '0;
    else               en_run <= en_run + 1'b1;
  end

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_e1_n && !mem_e2));
  assert_strobe_leads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_e1_n) |-> ($past(mem_we_n) == 1'b0));
  assert_no_en_without_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_e1_n |-> !mem_we_n);
  assert_en_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_e1_n) |-> (en_run == 8'(N_EN)));
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |->
      ($stable(mem_addr) && $stable(mem_bank) && $stable(mem_dq_out)));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb;
  localparam int AW = 8, BW = 2, DW = 16, GRADE = 0, CLK_NS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_bank = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, mem_e1_n, mem_e2, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_bank;
  logic [DW-1:0] mem_dq_out;

  int checks = 0, errors = 0;
  logic [DW-1:0] model_mem [0:(1<<(AW+BW))-1];
  logic [DW-1:0] ref_mem   [0:(1<<(AW+BW))-1];
  logic          written   [0:(1<<(AW+BW))-1];

  always #2 clk = ~clk;

  sram_wr_seq #(.AW(AW), .BW(BW), .DW(DW), .GRADE(GRADE), .CLK_NS(CLK_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bank(req_bank), .req_data(req_data), .done(done),
    .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_e1_n(mem_e1_n), .mem_e2(mem_e2),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  // Expected cycle counts from the grade table (R7).
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int exp_en();
    int ew, av, dv, n;
    ew = (GRADE == 2) ? 20 : (GRADE == 1) ? 15 : 12;
    av = (GRADE == 2) ? 30 : (GRADE == 1) ? 20 : 15;
    dv = (GRADE == 2) ? 15 : (GRADE == 1) ? 10 : 8;
    n = cdiv(ew, CLK_NS);
    if (cdiv(av, CLK_NS) - 1 > n) n = cdiv(av, CLK_NS) - 1;
    if (cdiv(dv, CLK_NS) - 1 > n) n = cdiv(dv, CLK_NS) - 1;
    return (n < 1) ? 1 : n;
  endfunction
  function automatic int exp_rec();
    int cyc, n;
    cyc = (GRADE == 2) ? 35 : (GRADE == 1) ? 25 : 20;
    n = cdiv(cyc, CLK_NS) - exp_en() - 2;
    return (n < 1) ? 1 : n;
  endfunction
  // Expected {we_n, e1_n, e2, oe, ready, done} at cycle i after acceptance.
  function automatic logic [5:0] exp_pins(input int i);
    if (i == 1)                          return 6'b0_1_0_1_0_0;
    if (i <= exp_en() + 1)               return 6'b0_0_1_1_0_0;
    if (i == exp_en() + 2)               return 6'b0_1_0_1_0_0;
    if (i <= exp_en() + 2 + exp_rec())   return 6'b1_1_0_0_0_0;
    return 6'b1_1_0_0_1_1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // Memory model: data is taken when the enables close while the strobe is low.
  logic en_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (en_prev && !(!mem_e1_n && mem_e2) && !mem_we_n)
        model_mem[{mem_bank, mem_addr}] = mem_dq_out;
      if (!mem_e1_n && mem_we_n) begin
        errors++; checks++;
        $display("FAIL R2: actual we_n %b expected 0 while enabled", mem_we_n);
      end
    end
    en_prev = !mem_e1_n && mem_e2;
  end

  // Called at a negedge. Drives a request and checks every cycle of its write.
  task automatic do_write(input logic [AW-1:0] a, input logic [BW-1:0] b,
                          input logic [DW-1:0] d, input bit noise);
    int total;
    logic [5:0] got, expv;
    req_valid = 1'b1; req_addr = a; req_bank = b; req_data = d;
    while (!req_ready) @(negedge clk);
    total = exp_en() + exp_rec() + 3;
    for (int i = 1; i <= total; i++) begin
      @(negedge clk);
      if (i == 1 || noise) begin
        req_valid = noise ? 1'($urandom) : 1'b0;
        req_addr = AW'($urandom); req_bank = BW'($urandom); req_data = DW'($urandom);
      end
      got  = {mem_we_n, mem_e1_n, mem_e2, mem_dq_oe, req_ready, done};
      expv = exp_pins(i);
      chk(got[5] == expv[5], "R2", 32'(got), 32'(expv));
      chk(got[4:3] == expv[4:3], "R3", 32'(got), 32'(expv));
      chk(got[2] == expv[2], "R5", 32'(got), 32'(expv));
      chk(got[1:0] == expv[1:0], (i == total) ? "R6" : "R1", 32'(got), 32'(expv));
      chk({mem_bank, mem_addr, mem_dq_out} == {b, a, d}, "R4",
          32'({mem_bank, mem_addr, mem_dq_out}), 32'({b, a, d}));
    end
    req_valid = 1'b0;
    ref_mem[{b, a}] = d;
    written[{b, a}] = 1'b1;
  endtask

  task automatic idle_check(input logic [AW-1:0] a);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R6", 32'({done, req_ready}), 32'b01);
    chk(mem_addr == a && mem_we_n && mem_e1_n, "R1", 32'(mem_addr), 32'(a));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < (1 << (AW + BW)); k++) begin
      written[k] = 1'b0; model_mem[k] = '0; ref_mem[k] = '0;
    end
    repeat (3) @(negedge clk);
    chk({mem_we_n, mem_e1_n, mem_e2, mem_dq_oe, req_ready, done} == 6'b110010, "R8",
        32'({mem_we_n, mem_e1_n, mem_e2, mem_dq_oe, req_ready, done}), 32'b110010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(exp_en() == 3 && exp_rec() == 1, "R7", 32'(exp_en()), 32'd3);

    // Directed corners.
    do_write('0, '0, '0, 1'b0);                 idle_check('0);
    do_write('1, '1, '1, 1'b0);                 idle_check('1);
    do_write(8'h5a, 2'd1, 16'hA5C3, 1'b1);      idle_check(8'h5a);

    // Back-to-back chain: next request already valid in the done cycle (R9).
    do_write(8'h10, 2'd2, 16'h1111, 1'b0);
    do_write(8'h11, 2'd2, 16'h2222, 1'b0);
    do_write(8'h12, 2'd3, 16'h3333, 1'b1);
    idle_check(8'h12);

    // Random writes with busy-time noise and random idle gaps.
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      do_write(a, BW'($urandom), DW'($urandom), 1'($urandom));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    repeat (4) @(negedge clk);
    for (int k = 0; k < (1 << (AW + BW)); k++)
      if (written[k])
        chk(model_mem[k] == ref_mem[k], "R9", 32'(model_mem[k]), 32'(ref_mem[k]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule